// File: doc/BRIEF.md
# Line Brown-In/Brown-Out Qualifier

This block decides whether the rectified input line is strong enough for a switching converter to run. Each time the low-side switch is on, an external sensing path compares the line-proportional level against two thresholds and hands the block a strobe with two flags: one for "above the run level" and one for "above the stop level". The block ignores the flags on any cycle where no strobe arrives or switching is not active.

After every supply-undervoltage restart, the block first qualifies the line with test pulses. The first usable sample is thrown away. It then waits for one sample above the run level, which enables soft start, or for three low samples in a row, which raise a restart request. Once running, a sample at or below the stop level starts a long ripple-rejection window. Any sample above the stop level clears the window. When the window expires it does not shut the converter down. It only arms a pending fault, and that fault is confirmed by three fresh low samples or cancelled by one high sample. A pending fault can wait for any length of time while switching is paused.

The sample input is a valid-only stream with no back-pressure: the block accepts every strobe on the cycle it is presented, and there is no ready signal. All other pins are plain levels.

Top module: `lq_line_qualifier`

## Requirements
- R1: After an asynchronous reset, or one cycle after `uv_reset` is high, `softstart_en`, `restart_req` and `bo_fault` are all low and the block waits for test samples.
- R2: After a reset, the first qualified sample (`smp_valid` and `sw_active` both high) has no effect on the outputs, even when it shows the line above the run level.
- R3: During line qualification, a qualified sample with `above_run`=1 sets `softstart_en` high on the next clock cycle.
- R4: During line qualification, three consecutive qualified samples with `above_run`=0 set `restart_req` high on the next clock cycle, and `softstart_en` stays low.
- R5: A strobe is used only when `smp_valid` and `sw_active` are both high. Any other combination leaves every output and all counting unchanged.
- R6: While running, a qualified sample with `above_stop`=0 starts the ripple window. A qualified sample with `above_stop`=1 clears it, so a later low sample must wait a full new window of `TBO_CYCLES` clocks.
- R7: Low samples taken while the window is still open are not counted toward confirmation. Expiry of the window alone leaves `softstart_en` high and `bo_fault` low.
- R8: Once the window has expired, the fault stays pending through any pause in sampling. The third qualified low-stop sample after expiry sets `bo_fault` high and `softstart_en` low on the next cycle.
- R9: A qualified sample with `above_stop`=1 while the fault is pending cancels it. The block returns to running, and a fresh window is needed before confirmation can start again.
- R10: `bo_fault` and `restart_req` stay high until `uv_reset`. `uv_reset` overrides any sample presented in the same cycle.
- R11: At most one of `softstart_en`, `restart_req` and `bo_fault` is high at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_reset | input | 1 | Supply reached its turn-off level; restart qualification |
| smp_valid | input | 1 | Sample strobe, one cycle per switch on-time |
| sw_active | input | 1 | Switching is active; gates the strobe |
| above_run | input | 1 | Sensed line level is above the run threshold (synchronized) |
| above_stop | input | 1 | Sensed line level is above the stop threshold (synchronized) |
| softstart_en | output | 1 | Line qualified; converter may soft start and keep running |
| restart_req | output | 1 | Brown-in failed; request a new undervoltage restart |
| bo_fault | output | 1 | Latched brown-out fault |

## Verification
The bench builds the block with `TBO_CYCLES` = 20 and keeps the test-pulse and confirmation counts at 3. With such a short window, the bench can reach a cleared-then-restarted window, low samples taken inside the window, an expired window left idle for several times its length, and cancellation inside confirmation, all within a few hundred cycles. Because the window is this short, the bench can also show that a timer which was never cleared would already have expired, so a missed clear turns into a visible false fault.

// File: rtl/lq_pkg.sv
package lq_pkg;

  typedef enum logic [2:0] {
    LQ_IDLE    = 3'd0,
    LQ_TEST    = 3'd1,
    LQ_RUN     = 3'd2,
    LQ_TIMING  = 3'd3,
    LQ_VERIFY  = 3'd4,
    LQ_FAULT   = 3'd5
  } lq_state_e;

  typedef enum logic {
    CAUSE_BROWN_IN  = 1'b0,
    CAUSE_BROWN_OUT = 1'b1
  } lq_cause_e;

endpackage

// File: rtl/lq_sample_gate.sv
// Qualifies a strobe: it counts only while switching is active and no
// undervoltage restart is in progress. It then splits the flags into
// per-threshold events.
module lq_sample_gate (
  input  logic uv_reset,
  input  logic smp_valid,
  input  logic sw_active,
  input  logic above_run,
  input  logic above_stop,
  output logic take,
  output logic low_run,
  output logic high_run,
  output logic low_stop,
  output logic high_stop
);
  always_comb begin
    take      = smp_valid && sw_active && !uv_reset;
    low_run   = take && !above_run;
    high_run  = take &&  above_run;
    low_stop  = take && !above_stop;
    high_stop = take &&  above_stop;
  end
endmodule

// File: rtl/lq_streak_counter.sv
// Counts qualifying events toward LIMIT. hit is high on the event that
// completes the streak.
module lq_streak_counter #(
  parameter int LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic hit
);
  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt_q;

  assign hit = inc && (cnt_q == W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (hit)    cnt_q <= '0;
    else if (inc)    cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/lq_window_timer.sv
// Ripple-rejection window. It runs while run is high and clears as soon as
// run drops. expire is high during the final cycle of a LEN-cycle window.
module lq_window_timer #(
  parameter int LEN = 15_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int W = $clog2(LEN + 1);

  logic [W-1:0] cnt_q;

  assign expire = run && (cnt_q == W'(LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (!expire) cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/lq_line_qualifier.sv
module lq_line_qualifier
  import lq_pkg::*;
#(
  parameter int TBO_CYCLES     = 15_000_000,
  parameter int TEST_LOWS      = 3,
  parameter int VERIFY_SAMPLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_reset,
  input  logic smp_valid,
  input  logic sw_active,
  input  logic above_run,
  input  logic above_stop,
  output logic softstart_en,
  output logic restart_req,
  output logic bo_fault
);

  lq_state_e state_q, state_d;
  lq_cause_e cause_q, cause_d;

  logic take, low_run, high_run, low_stop, high_stop;
  logic test_hit, verify_hit, win_expire;

  lq_sample_gate u_gate (
    .uv_reset  (uv_reset),
    .smp_valid (smp_valid),
    .sw_active (sw_active),
    .above_run (above_run),
    .above_stop(above_stop),
    .take      (take),
    .low_run   (low_run),
    .high_run  (high_run),
    .low_stop  (low_stop),
    .high_stop (high_stop)
  );

  lq_streak_counter #(.LIMIT(TEST_LOWS)) u_test_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (uv_reset || (state_q != LQ_TEST)),
    .inc  (low_run && (state_q == LQ_TEST)),
    .hit  (test_hit)
  );

  lq_streak_counter #(.LIMIT(VERIFY_SAMPLES)) u_verify_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (uv_reset || (state_q != LQ_VERIFY)),
    .inc  (low_stop && (state_q == LQ_VERIFY)),
    .hit  (verify_hit)
  );

  lq_window_timer #(.LEN(TBO_CYCLES)) u_window (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state_q == LQ_TIMING),
    .expire(win_expire)
  );

  always_comb begin
    state_d = state_q;
    cause_d = cause_q;
    unique case (state_q)
      LQ_IDLE:   if (take) state_d = LQ_TEST;
      LQ_TEST: begin
        if (high_run) state_d = LQ_RUN;
        else if (test_hit) begin
          state_d = LQ_FAULT;
          cause_d = CAUSE_BROWN_IN;
        end
      end
      LQ_RUN:    if (low_stop) state_d = LQ_TIMING;
      LQ_TIMING: begin
        if (high_stop)       state_d = LQ_RUN;
        else if (win_expire) state_d = LQ_VERIFY;
      end
      LQ_VERIFY: begin
        if (high_stop) state_d = LQ_RUN;
        else if (verify_hit) begin
          state_d = LQ_FAULT;
          cause_d = CAUSE_BROWN_OUT;
        end
      end
      LQ_FAULT:  state_d = LQ_FAULT;
      default:   state_d = LQ_IDLE;
    endcase
    if (uv_reset) begin
      state_d = LQ_IDLE;
      cause_d = CAUSE_BROWN_IN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LQ_IDLE;
      cause_q <= CAUSE_BROWN_IN;
    end else begin
      state_q <= state_d;
      cause_q <= cause_d;
    end
  end

  always_comb begin
    softstart_en = (state_q == LQ_RUN) || (state_q == LQ_TIMING) ||
                   (state_q == LQ_VERIFY);
    restart_req  = (state_q == LQ_FAULT) && (cause_q == CAUSE_BROWN_IN);
    bo_fault     = (state_q == LQ_FAULT) && (cause_q == CAUSE_BROWN_OUT);
  end

endmodule

// File: rtl/lq_line_qualifier_chk.sv
module lq_line_qualifier_chk (
  input logic clk,
  input logic rst_n,
  input logic uv_reset,
  input logic smp_valid,
  input logic sw_active,
  input logic above_run,
  input logic above_stop,
  input logic softstart_en,
  input logic restart_req,
  input logic bo_fault
);
  logic used;
  assign used = smp_valid && sw_active && !uv_reset;

  AST_OUTPUTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({softstart_en, restart_req, bo_fault})); // R11

  AST_START_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(softstart_en) |-> $past(used && above_run)); // R3

  AST_BROWNIN_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(restart_req) |-> $past(used && !above_run)); // R4

  AST_FAULT_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bo_fault) |-> $past(used && !above_stop)); // R8

  AST_FAULT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    bo_fault && !uv_reset |=> bo_fault); // R10

  AST_RESTART_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req && !uv_reset |=> restart_req); // R10

  AST_UV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    uv_reset |=> !softstart_en && !restart_req && !bo_fault); // R1

  AST_IDLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !used && !uv_reset |=> $stable({softstart_en, restart_req, bo_fault})); // R5
endmodule

bind lq_line_qualifier lq_line_qualifier_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .uv_reset    (uv_reset),
  .smp_valid   (smp_valid),
  .sw_active   (sw_active),
  .above_run   (above_run),
  .above_stop  (above_stop),
  .softstart_en(softstart_en),
  .restart_req (restart_req),
  .bo_fault    (bo_fault)
);

// File: tb/lq_line_qualifier_bench.sv
module lq_line_qualifier_bench;
  localparam int TBO = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uv_reset = 1'b0;
  logic smp_valid = 1'b0;
  logic sw_active = 1'b0;
  logic above_run = 1'b0;
  logic above_stop = 1'b0;
  logic softstart_en, restart_req, bo_fault;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  lq_line_qualifier #(.TBO_CYCLES(TBO), .TEST_LOWS(3), .VERIFY_SAMPLES(3)) u_lq_line_qualifier (
    .clk(clk), .rst_n(rst_n), .uv_reset(uv_reset), .smp_valid(smp_valid),
    .sw_active(sw_active), .above_run(above_run), .above_stop(above_stop),
    .softstart_en(softstart_en), .restart_req(restart_req), .bo_fault(bo_fault)
  );

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {ss,rr,bo} actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [2:0] outs();
    return {softstart_en, restart_req, bo_fault};
  endfunction

  task automatic strobe(input logic v, input logic sw, input logic ar, input logic as_);
    @(negedge clk);
    smp_valid = v; sw_active = sw; above_run = ar; above_stop = as_;
    @(negedge clk);
    smp_valid = 1'b0; sw_active = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic uv();
    @(negedge clk); uv_reset = 1'b1;
    @(negedge clk); uv_reset = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 after reset", outs(), 3'b000);
  endtask

  task automatic t_discard();
    uv();
    strobe(1, 1, 1, 1);
    chk("R2 first sample discarded", outs(), 3'b000);
    strobe(1, 1, 1, 1);
    chk("R3 high sample starts", outs(), 3'b100);
  endtask

  task automatic t_brownin_fail();
    uv();
    strobe(1, 1, 1, 1);
    strobe(1, 1, 0, 0);
    strobe(1, 1, 0, 0);
    chk("R4 two lows not enough", outs(), 3'b000);
    strobe(1, 1, 0, 0);
    chk("R4 third low requests restart", outs(), 3'b010);
    strobe(1, 1, 1, 1);
    idle(30);
    chk("R10 restart held", outs(), 3'b010);
    uv();
    chk("R1 uv clears restart", outs(), 3'b000);
  endtask

  task automatic t_ignored();
    uv();
    strobe(1, 1, 1, 1);
    strobe(1, 0, 1, 1);
    chk("R5 strobe without switching ignored", outs(), 3'b000);
    strobe(0, 1, 1, 1);
    chk("R5 flags without strobe ignored", outs(), 3'b000);
    strobe(1, 0, 0, 0); strobe(1, 0, 0, 0); strobe(1, 0, 0, 0);
    chk("R5 unqualified lows not counted", outs(), 3'b000);
    strobe(1, 1, 0, 0); strobe(1, 1, 0, 0);
    strobe(1, 1, 1, 1);
    chk("R3 high after two lows starts", outs(), 3'b100);
  endtask

  task automatic t_timer_clear();
    strobe(1, 1, 1, 0);
    idle(15);
    strobe(1, 1, 1, 1);
    idle(15);
    strobe(1, 1, 1, 0);
    strobe(1, 1, 1, 0); strobe(1, 1, 1, 0); strobe(1, 1, 1, 0);
    chk("R6 R7 cleared window, lows inside not counted", outs(), 3'b100);
    idle(TBO + 5);
    chk("R7 expiry alone keeps running", outs(), 3'b100);
    idle(5 * TBO);
    chk("R8 pending held through pause", outs(), 3'b100);
    strobe(1, 1, 1, 0); strobe(1, 1, 1, 0);
    chk("R8 two confirmations not enough", outs(), 3'b100);
    strobe(1, 1, 1, 0);
    chk("R8 third confirmation raises fault", outs(), 3'b001);
    strobe(1, 1, 1, 1);
    idle(10);
    chk("R10 fault latched", outs(), 3'b001);
  endtask

  task automatic t_verify_cancel();
    uv();
    chk("R1 uv clears fault", outs(), 3'b000);
    strobe(1, 1, 0, 0);
    strobe(1, 1, 1, 1);
    strobe(1, 1, 1, 0);
    idle(TBO + 5);
    strobe(1, 1, 1, 0); strobe(1, 1, 1, 0);
    strobe(1, 1, 1, 1);
    chk("R9 high cancels pending", outs(), 3'b100);
    strobe(1, 1, 1, 0); strobe(1, 1, 1, 0); strobe(1, 1, 1, 0);
    chk("R9 fresh window needed", outs(), 3'b100);
    idle(TBO + 5);
    strobe(1, 1, 1, 0); strobe(1, 1, 1, 0); strobe(1, 1, 1, 0);
    chk("R8 fault after fresh window", outs(), 3'b001);
    @(negedge clk);
    uv_reset = 1'b1; smp_valid = 1'b1; sw_active = 1'b1; above_run = 1'b1; above_stop = 1'b1;
    @(negedge clk);
    uv_reset = 1'b0; smp_valid = 1'b0;
    chk("R10 uv overrides sample", outs(), 3'b000);
    strobe(1, 1, 1, 1);
    chk("R2 discard after uv with sample", outs(), 3'b000);
    strobe(1, 1, 1, 1);
    chk("R11 only soft start high", outs(), 3'b100);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    sw_active = 1'b1;
    idle(2);
    t_reset();
    t_discard();
    t_brownin_fail();
    t_ignored();
    t_timer_clear();
    t_verify_cancel();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule